// File: doc/BRIEF.md
# Sign-Pattern QPSK Symbol Detector

This block recovers QPSK dibits without a local oscillator, mixer or low-pass filter. Signed ADC samples arrive at eight per carrier cycle, so neighbouring samples lie 45 degrees of carrier phase apart. The block keeps only the sign of every second sample, at in-symbol positions 1, 3, 5 and 7. That gives four polarity decisions per symbol, which are gathered into one parallel word.

When the fourth decision arrives, the word is compared in parallel against four stored sign patterns, one for each QPSK phase. A full match produces that phase's dibit together with a one-cycle valid strobe. A word that matches no pattern produces a one-cycle no-match flag in place of the strobe. Amplitude plays no part in the decision, so gain changes and phase offsets that leave every used sign unchanged still decode correctly.

Symbol timing comes from outside. A start marker that arrives with a sample tags that sample as position 0 of a new symbol. With no marker, the position counter simply wraps after eight accepted samples.

Top module: `qpsk_sign_demod`

## Requirements
- R1: After a synchronous reset, `sym_valid` and `sym_nomatch` are 0, `sym_dibit` is 00, and the next accepted sample counts as position 0 of a symbol.
- R2: A sample is negative when its two's-complement most significant bit is 1 and positive otherwise, so a sample of exactly 0 counts as positive. The magnitude of a sample never changes the result.
- R3: Only the samples at positions 1, 3, 5 and 7 affect the decision. The samples at positions 0, 2, 4 and 6 have no effect.
- R4: The signs at positions 1, 3, 5 and 7 map to dibits as follows: +,-,-,+ gives 00; -,-,+,+ gives 01; -,+,+,- gives 11; +,+,-,- gives 10.
- R5: `sym_valid` pulses high for exactly one cycle, in the cycle that follows the clock edge that accepts the position-7 sample. `sym_dibit` carries the decoded value in that same cycle.
- R6: A sign word that matches none of the four patterns raises `sym_nomatch` for one cycle in place of `sym_valid`, and `sym_dibit` keeps its previous value.
- R7: A sample accepted with `smp_start` high is position 0, even in the middle of a symbol. The partial symbol in progress is dropped and produces no output.
- R8: While `smp_valid` is 0, the sample and the start marker are ignored, and the sample position does not advance.
- R9: Without a start marker, the position after 7 wraps to 0, so consecutive symbols decode back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_data | input | SAMPLE_W | Signed ADC sample |
| smp_valid | input | 1 | Sample present this cycle |
| smp_start | input | 1 | Marks the sample as position 0 of a symbol |
| sym_dibit | output | 2 | Decoded dibit |
| sym_valid | output | 1 | One-cycle strobe for a matched symbol |
| sym_nomatch | output | 1 | One-cycle flag for an unmatched symbol |

## Verification
A wrong position count shows up on the very next symbol. The strobe moves off the cycle after the eighth accepted sample, or the sign word picks up an even-position sample and yields the wrong dibit or a spurious no-match. A stale or misrouted polarity slot corrupts one bit of the sign word. That turns a known pattern into a different dibit or a no-match flag in the cycle after the symbol completes. A table entry that is swapped or duplicated shows up in the first symbol that uses it. Pattern vectors whose even-position samples carry hostile signs expose any leak from unused samples within one symbol.

// File: rtl/qpsk_sign_pkg.sv
package qpsk_sign_pkg;

    localparam int SAMPLES_PER_SYM = 8;
    localparam int DECIM           = 2;
    localparam int POL_PER_SYM     = SAMPLES_PER_SYM / DECIM;
    localparam int CNT_W           = $clog2(SAMPLES_PER_SYM);
    localparam int SLOT_W          = CNT_W - $clog2(DECIM);
    localparam int NUM_REF         = 4;

    // bit set = negative sample; MSB holds position 1, LSB position 7
    typedef logic [POL_PER_SYM-1:0] sign_word_t;
    typedef logic [1:0]             dibit_t;

    typedef struct packed {
        sign_word_t pat;
        dibit_t     sym;
    } ref_entry_t;

    function automatic ref_entry_t ref_entry(input int unsigned k);
        ref_entry_t e;
        case (k)
            0:       e = '{pat: 4'b0110, sym: 2'b00};
            1:       e = '{pat: 4'b1100, sym: 2'b01};
            2:       e = '{pat: 4'b1001, sym: 2'b11};
            default: e = '{pat: 4'b0011, sym: 2'b10};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/sign_slicer.sv
module sign_slicer #(
    parameter int SAMPLE_W = 12
) (
    input  logic signed [SAMPLE_W-1:0] sample,
    output logic                       is_neg
);
    // zero has a clear MSB and therefore falls on the positive side
    assign is_neg = sample[SAMPLE_W-1];
endmodule

// File: rtl/polarity_collector.sv
module polarity_collector
    import qpsk_sign_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       acc,
    input  logic       start,
    input  logic       is_neg,
    output logic       word_done,
    output sign_word_t word
);
    logic [CNT_W-1:0]  pos_q;
    logic [CNT_W-1:0]  pos;
    logic [SLOT_W-1:0] slot;
    logic              used;
    logic [POL_PER_SYM-2:0] pol_q;

    assign pos  = start ? '0 : pos_q;
    assign used = (pos % CNT_W'(DECIM)) == CNT_W'(DECIM - 1);
    assign slot = SLOT_W'(pos / CNT_W'(DECIM));

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (acc)
            pos_q <= (pos == CNT_W'(SAMPLES_PER_SYM - 1)) ? '0 : pos + 1'b1;
    end

    genvar s;
    generate
        for (s = 0; s < POL_PER_SYM - 1; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    pol_q[s] <= 1'b0;
                else if (acc && used && slot == SLOT_W'(s))
                    pol_q[s] <= is_neg;
            end
            assign word[POL_PER_SYM-1-s] = pol_q[s];
        end
    endgenerate

    assign word[0]   = is_neg;
    assign word_done = acc && (pos == CNT_W'(SAMPLES_PER_SYM - 1));

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(pos_q));

    // R7
    restart_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && start) |=> (pos_q == CNT_W'(1)));

endmodule

// File: rtl/pattern_matcher.sv
module pattern_matcher
    import qpsk_sign_pkg::*;
(
    input  sign_word_t word,
    output logic       hit,
    output dibit_t     sym
);
    logic [NUM_REF-1:0] hits;

    genvar k;
    generate
        for (k = 0; k < NUM_REF; k++) begin : g_ref
            assign hits[k] = (word == ref_entry(k).pat);
        end
    endgenerate

    always_comb begin
        sym = '0;
        for (int i = 0; i < NUM_REF; i++)
            if (hits[i]) sym = sym | ref_entry(i).sym;
    end

    assign hit = |hits;

    // R4
    always_comb begin
        ref_unique_chk: assert ($onehot0(hits));
    end

endmodule

// File: rtl/qpsk_sign_demod.sv
module qpsk_sign_demod
    import qpsk_sign_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                smp_valid,
    input  logic                smp_start,
    output logic [1:0]          sym_dibit,
    output logic                sym_valid,
    output logic                sym_nomatch
);
    logic       is_neg;
    logic       word_done;
    sign_word_t word;
    logic       hit;
    dibit_t     match_sym;

    sign_slicer #(.SAMPLE_W(SAMPLE_W)) u_slice (
        .sample (smp_data),
        .is_neg (is_neg)
    );

    polarity_collector u_coll (
        .clk       (clk),
        .rst       (rst),
        .acc       (smp_valid),
        .start     (smp_start),
        .is_neg    (is_neg),
        .word_done (word_done),
        .word      (word)
    );

    pattern_matcher u_match (
        .word (word),
        .hit  (hit),
        .sym  (match_sym)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_dibit   <= '0;
            sym_valid   <= 1'b0;
            sym_nomatch <= 1'b0;
        end else begin
            sym_valid   <= word_done && hit;
            sym_nomatch <= word_done && !hit;
            if (word_done && hit)
                sym_dibit <= match_sym;
        end
    end

    // R5
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        word_done |=> (sym_valid ^ sym_nomatch));

    // R5
    strobe_source_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_valid || sym_nomatch) |-> $past(word_done));

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sym_valid |=> !sym_valid);

    // R6
    nomatch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sym_nomatch |-> $stable(sym_dibit));

endmodule

// File: tb/sim_qpsk_sign_demod.sv
module sim_qpsk_sign_demod;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] smp_data;
    logic         smp_valid;
    logic         smp_start;
    logic [1:0]   sym_dibit;
    logic         sym_valid;
    logic         sym_nomatch;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    qpsk_sign_demod #(.SAMPLE_W(W)) u0 (
        .clk         (clk),
        .rst         (rst),
        .smp_data    (smp_data),
        .smp_valid   (smp_valid),
        .smp_start   (smp_start),
        .sym_dibit   (sym_dibit),
        .sym_valid   (sym_valid),
        .sym_nomatch (sym_nomatch)
    );

    // {sign word (1 = negative, MSB = position 1), expect no-match, dibit}
    localparam logic [6:0] VEC [10] = '{
        7'b0110_0_00, 7'b1100_0_01, 7'b1001_0_11, 7'b0011_0_10,
        7'b0000_1_00, 7'b0011_0_10, 7'b1111_1_00, 7'b0110_0_00,
        7'b0101_1_00, 7'b1001_0_11
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mk(input int v);
        return W'(v);
    endfunction

    // drives one symbol; returns at the negedge after the final sample's capture edge
    task automatic send_sym(input logic [3:0] pat, input int amp, input bit start,
                            input bit gaps, input bit zero_pos);
        for (int k = 0; k < 8; k++) begin
            if (gaps) begin
                @(negedge clk);
                smp_valid = 1'b0;
                smp_start = 1'b1;
                smp_data  = (k % 2 == 1 && !pat[3 - k/2]) ? mk(-amp) : mk(amp);
            end
            @(negedge clk);
            smp_valid = 1'b1;
            smp_start = start && (k == 0);
            if (k % 2 == 1)
                smp_data = pat[3 - k/2] ? mk(-amp) : (zero_pos ? mk(0) : mk(amp));
            else
                smp_data = (((k + amp) % 3) == 0) ? mk(-amp) : mk(amp + 5);
        end
        @(negedge clk);
        smp_valid = 1'b0;
        smp_start = 1'b0;
    endtask

    task automatic expect_out(input bit nm, input logic [1:0] d, input string req);
        chk(sym_valid == !nm, req, sym_valid, !nm);
        chk(sym_nomatch == nm, req, sym_nomatch, nm);
        chk(sym_dibit == d, req, sym_dibit, d);
        @(negedge clk);
        chk(!sym_valid && !sym_nomatch, {req, " pulse width"}, sym_valid | sym_nomatch, 0);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [1:0] last;
        rst = 1'b1; smp_valid = 1'b0; smp_start = 1'b0; smp_data = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sym_valid == 0 && sym_nomatch == 0, "R1", sym_valid | sym_nomatch, 0);
        chk(sym_dibit == 2'b00, "R1 dibit", sym_dibit, 0);
        rst = 1'b0;

        // R4 R3 R2 R6: vector walk, amplitude varies, even samples hostile
        last = 2'b00;
        for (int i = 0; i < 10; i++) begin
            send_sym(VEC[i][6:3], 100 + i * 190, 1'b1, 1'b0, 1'b0);
            if (!VEC[i][2]) last = VEC[i][1:0];
            expect_out(VEC[i][2], last, VEC[i][2] ? "R6 nomatch" : "R4 R3 R2 map");
        end

        // R2 exact zero counts as positive: ++-- with zeros -> 10
        send_sym(4'b0011, 700, 1'b1, 1'b0, 1'b1);
        expect_out(1'b0, 2'b10, "R2 zero");

        // R6 dibit held on no-match after 01
        send_sym(4'b1100, 300, 1'b1, 1'b0, 1'b0);
        expect_out(1'b0, 2'b01, "R6 setup");
        send_sym(4'b1110, 300, 1'b1, 1'b0, 1'b0);
        expect_out(1'b1, 2'b01, "R6 hold");

        // R9 back-to-back without marker
        send_sym(4'b1001, 400, 1'b1, 1'b0, 1'b0);
        expect_out(1'b0, 2'b11, "R9 first");
        send_sym(4'b0110, 900, 1'b0, 1'b0, 1'b0);
        expect_out(1'b0, 2'b00, "R9 wrap");

        // R7 restart mid-symbol: five stray samples then a marked symbol
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            smp_valid = 1'b1; smp_start = (k == 0); smp_data = mk(-50);
        end
        @(negedge clk);
        smp_valid = 1'b0; smp_start = 1'b0;
        chk(!sym_valid && !sym_nomatch, "R7 no early output", sym_valid | sym_nomatch, 0);
        send_sym(4'b0011, 500, 1'b1, 1'b0, 1'b0);
        expect_out(1'b0, 2'b10, "R7 restart");

        // R8 gaps with invalid data and stray markers in between
        send_sym(4'b1100, 250, 1'b1, 1'b1, 1'b0);
        expect_out(1'b0, 2'b01, "R8 gaps");

        // R1 reset mid-symbol restarts position
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            smp_valid = 1'b1; smp_start = (k == 0); smp_data = mk(20);
        end
        @(negedge clk);
        smp_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(sym_dibit == 2'b00 && !sym_valid, "R1 mid reset", sym_dibit, 0);
        send_sym(4'b1001, 600, 1'b0, 1'b0, 1'b0);
        expect_out(1'b0, 2'b11, "R1 position cleared");

        summary();
        $finish;
    end
endmodule